// File: doc/BRIEF.md
# Disk sector address sequencer

This block keeps the target address for a controller that serves two moving-head disk drives. One shared target register holds a cylinder, a head and a sector. The host loads it with two data words. Each drive also keeps its own cylinder and head position. That position is copied from the shared register when a positioning command completes, and cleared by a recalibrate.

When a transfer runs, the controller strobes `sector_start` at each sector boundary. The block then checks the shared register against the selected drive's position. If the check passes, it registers a linear sector index one cycle later. It counts the data words of the sector. After the last word it steps the sector number and, on a wrap, the head. Check operations count down a sector budget. The address-readback operation returns two words that describe the current position. In a write, every word slot yields either the host word or a zero fill word.

Top module: `disk_addr_seq`

## Requirements
- R1: After reset, the shared register, both drive positions, `busy`, the three error flags, `index_valid` and `op_done` are all zero.
- R2: While idle, `ld_cyl` loads the cylinder from `din[7:0]`. `ld_hs` loads the head from `din[12:8]` and the sector from `din[4:0]`. `pos_load` copies the register's cylinder and head into the drive selected by `drv_sel`. `recal` clears the register and the selected drive's position. `ld_count` loads the check budget. While `busy` is high, all of these inputs are ignored.
- R3: At an accepted `sector_start`, an address error is raised if the register's cylinder or head differs from the selected drive's position, or if the sector is 23 or more. This sets `addr_err` and ends the operation, in read, write and check modes alike.
- R4: If the address matches but the head is 20 or more, `eoc_err` is set and the operation ends.
- R5: A `sector_start` in write mode on a drive whose `wr_prot` bit is set raises `prot_err` and ends the operation. This takes precedence over the address checks. At most one error flag is ever set.
- R6: One cycle after a passing `sector_start`, `sector_index` equals ((cylinder*20 + head)*23 + sector) of the register, and `index_valid` is high.
- R7: After the 128th `word_done` of a sector, the register's sector advances modulo 23. When it wraps to 0, the head increments both in the register and in the selected drive's position.
- R8: In check mode, the budget taken from `din[8:0]` decrements after each full sector, and the operation ends once it reaches zero.
- R9: In address-readback mode, the first `addr_read` returns the drive's cylinder on `rb_word`. The second returns the drive's head in bits 12:8 and the register's sector in bits 4:0. It then advances the sector modulo 23, leaves the head unchanged, and ends the operation.
- R10: In write mode, each `word_done` sets `fill_word` to `host_word` if `host_valid` is high, and to zero otherwise.
- R11: `op_done` pulses for exactly one cycle whenever an operation ends, whether by error, by completion or by `op_stop`. `op_mode` encodes the modes as 0 for read, 1 for write, 2 for check and 3 for address readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 16 | Host data word for register and count loads |
| ld_cyl | input | 1 | Load register cylinder |
| ld_hs | input | 1 | Load register head and sector |
| pos_load | input | 1 | Copy register cylinder/head into the selected drive |
| recal | input | 1 | Clear the register and the selected drive's position |
| drv_sel | input | 1 | Selected drive |
| wr_prot | input | 2 | Per-drive write protect |
| ld_count | input | 1 | Load the check sector budget |
| op_start | input | 1 | Begin an operation in `op_mode` |
| op_mode | input | 2 | 0 read, 1 write, 2 check, 3 address readback |
| op_stop | input | 1 | End the running operation |
| sector_start | input | 1 | Sector boundary strobe |
| word_done | input | 1 | One data word slot passed |
| addr_read | input | 1 | Request the next readback word |
| host_valid | input | 1 | Host write word present for this slot |
| host_word | input | 16 | Host write word |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | One-cycle end-of-operation pulse |
| addr_err | output | 1 | Address miscompare or bad sector |
| eoc_err | output | 1 | Head past the last track |
| prot_err | output | 1 | Write to a protected drive |
| sector_index | output | 18 | Linear index of the accepted sector |
| index_valid | output | 1 | `sector_index` holds a valid value |
| fill_word | output | 16 | Word stored for the last write slot |
| rb_word | output | 16 | Address readback word |
| rb_valid | output | 1 | `rb_word` updated this cycle |
| rar_cyl | output | 8 | Shared register cylinder |
| rar_head | output | 5 | Shared register head |
| rar_sec | output | 5 | Shared register sector |
| pos_cyl | output | 8 | Selected drive cylinder |
| pos_head | output | 5 | Selected drive head |

## Verification
The hardest case to reach is a sector wrap during a transfer: the head must move in both the shared register and the drive, and the next sector must still compare cleanly. The bench gets there by loading sector 22 into the register and transferring a full 128-word sector. It then confirms that both heads read one higher and that a second `sector_start` is accepted with the new index. The check-mode budget is exercised across two full sectors in the same way. Write protection is tested together with a deliberate miscompare, to show that protection takes precedence.

// File: rtl/das_pkg.sv
package das_pkg;
  typedef enum logic [1:0] {
    MODE_READ  = 2'd0,
    MODE_WRITE = 2'd1,
    MODE_CHECK = 2'd2,
    MODE_ADDR  = 2'd3
  } op_mode_e;
endpackage

// File: rtl/das_rar.sv
// Shared target register: cylinder, head, sector.
module das_rar #(
  parameter int CYL_W  = 8,
  parameter int HEAD_W = 5,
  parameter int SEC_W  = 5,
  parameter int SECS   = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              ld_cyl_i,
  input  logic              ld_hs_i,
  input  logic [CYL_W-1:0]  cyl_in,
  input  logic [HEAD_W-1:0] head_in,
  input  logic [SEC_W-1:0]  sec_in,
  input  logic              adv_i,
  input  logic              carry_i,
  output logic [CYL_W-1:0]  cyl_o,
  output logic [HEAD_W-1:0] head_o,
  output logic [SEC_W-1:0]  sec_o,
  output logic              wrap_o
);
  localparam logic [SEC_W-1:0] SEC_LAST = SEC_W'(SECS - 1);

  logic [CYL_W-1:0]  cyl_q, cyl_d;
  logic [HEAD_W-1:0] head_q, head_d;
  logic [SEC_W-1:0]  sec_q, sec_d;

  assign wrap_o = adv_i && carry_i && (sec_q == SEC_LAST);

  always_comb begin
    cyl_d  = cyl_q;
    head_d = head_q;
    sec_d  = sec_q;
    if (clr_i) begin
      cyl_d  = '0;
      head_d = '0;
      sec_d  = '0;
    end else if (ld_cyl_i || ld_hs_i) begin
      if (ld_cyl_i) cyl_d = cyl_in;
      if (ld_hs_i) begin
        head_d = head_in;
        sec_d  = sec_in;
      end
    end else if (adv_i) begin
      sec_d = (sec_q == SEC_LAST) ? '0 : sec_q + 1'b1;
      if (wrap_o) head_d = head_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyl_q  <= '0;
      head_q <= '0;
      sec_q  <= '0;
    end else begin
      cyl_q  <= cyl_d;
      head_q <= head_d;
      sec_q  <= sec_d;
    end
  end

  assign cyl_o  = cyl_q;
  assign head_o = head_q;
  assign sec_o  = sec_q;

  // R7: an advance from a valid sector never leaves the sector out of range
  a_r7_sec_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !clr_i && !ld_hs_i) |=> (sec_q < SEC_W'(SECS)));
endmodule

// File: rtl/das_drive_bank.sv
// Per-drive cylinder/head position registers.
module das_drive_bank #(
  parameter int NUM_DRV = 2,
  parameter int CYL_W   = 8,
  parameter int HEAD_W  = 5,
  localparam int DRV_W  = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DRV_W-1:0]  sel_i,
  input  logic              load_i,
  input  logic              clr_i,
  input  logic              head_inc_i,
  input  logic [CYL_W-1:0]  rar_cyl,
  input  logic [HEAD_W-1:0] rar_head,
  output logic [CYL_W-1:0]  sel_cyl_o,
  output logic [HEAD_W-1:0] sel_head_o
);
  logic [CYL_W-1:0]  cyl_all  [NUM_DRV];
  logic [HEAD_W-1:0] head_all [NUM_DRV];

  for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
    logic [CYL_W-1:0]  cyl_q, cyl_d;
    logic [HEAD_W-1:0] head_q, head_d;
    logic              hit;

    assign hit = (sel_i == DRV_W'(g));

    always_comb begin
      cyl_d  = cyl_q;
      head_d = head_q;
      if (hit) begin
        if (clr_i) begin
          cyl_d  = '0;
          head_d = '0;
        end else if (load_i) begin
          cyl_d  = rar_cyl;
          head_d = rar_head;
        end else if (head_inc_i) begin
          head_d = head_q + 1'b1;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cyl_q  <= '0;
        head_q <= '0;
      end else begin
        cyl_q  <= cyl_d;
        head_q <= head_d;
      end
    end

    assign cyl_all[g]  = cyl_q;
    assign head_all[g] = head_q;
  end

  assign sel_cyl_o  = cyl_all[sel_i];
  assign sel_head_o = head_all[sel_i];

  // R7: a head step moves the selected drive's head by exactly one
  a_r7_drive_head_step: assert property (@(posedge clk) disable iff (!rst_n)
    (head_inc_i && !load_i && !clr_i) |=>
      ((sel_i != $past(sel_i)) || (sel_head_o == HEAD_W'($past(sel_head_o) + 1'b1))));
endmodule

// File: rtl/das_ctrl.sv
// Operation control: sector check, word count, budget, readback, fill.
module das_ctrl
  import das_pkg::*;
#(
  parameter int CYL_W    = 8,
  parameter int HEAD_W   = 5,
  parameter int SEC_W    = 5,
  parameter int SECS     = 23,
  parameter int HEADS    = 20,
  parameter int WORDS    = 128,
  parameter int CNT_W    = 9,
  parameter int DATA_W   = 16,
  parameter int HEAD_LSB = 8,
  parameter int IDX_W    = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_start,
  input  logic [1:0]        op_mode,
  input  logic              op_stop,
  input  logic              sector_start,
  input  logic              word_done,
  input  logic              addr_read,
  input  logic              ld_count,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic              host_valid,
  input  logic [DATA_W-1:0] host_word,
  input  logic              wprot,
  input  logic [CYL_W-1:0]  rar_cyl,
  input  logic [HEAD_W-1:0] rar_head,
  input  logic [SEC_W-1:0]  rar_sec,
  input  logic [CYL_W-1:0]  pos_cyl,
  input  logic [HEAD_W-1:0] pos_head,
  output logic              busy_o,
  output logic              addr_err_o,
  output logic              eoc_err_o,
  output logic              prot_err_o,
  output logic              done_o,
  output logic [IDX_W-1:0]  index_o,
  output logic              index_valid_o,
  output logic [DATA_W-1:0] fill_o,
  output logic [DATA_W-1:0] rb_word_o,
  output logic              rb_valid_o,
  output logic              adv_o,
  output logic              carry_o
);
  localparam int WPTR_W  = $clog2(WORDS);
  localparam int IDX_MAX = (2 ** CYL_W) * HEADS * SECS;

  op_mode_e          mode_q, mode_d;
  logic              busy_q, busy_d, in_sec_q, in_sec_d, rb_ph_q, rb_ph_d;
  logic              aerr_q, aerr_d, eoc_q, eoc_d, perr_q, perr_d;
  logic              done_q, done_d, idxv_q, idxv_d, rbv_q, rbv_d;
  logic [WPTR_W-1:0] wptr_q, wptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [IDX_W-1:0]  idx_q, idx_d, idx_calc;
  logic [DATA_W-1:0] fill_q, fill_d, rb_q, rb_d;
  logic              addr_bad, head_bad, finish;

  assign addr_bad = (rar_cyl != pos_cyl) || (rar_head != pos_head) ||
                    (rar_sec >= SEC_W'(SECS));
  assign head_bad = (rar_head >= HEAD_W'(HEADS));
  assign idx_calc = (IDX_W'(rar_cyl) * IDX_W'(HEADS) + IDX_W'(rar_head)) *
                    IDX_W'(SECS) + IDX_W'(rar_sec);

  always_comb begin
    mode_d   = mode_q;
    busy_d   = busy_q;
    in_sec_d = in_sec_q;
    rb_ph_d  = rb_ph_q;
    aerr_d   = aerr_q;
    eoc_d    = eoc_q;
    perr_d   = perr_q;
    idxv_d   = idxv_q;
    wptr_d   = wptr_q;
    cnt_d    = cnt_q;
    idx_d    = idx_q;
    fill_d   = fill_q;
    rb_d     = rb_q;
    done_d   = 1'b0;
    rbv_d    = 1'b0;
    adv_o    = 1'b0;
    carry_o  = 1'b0;
    finish   = 1'b0;
    if (!busy_q) begin
      if (op_start) begin
        busy_d   = 1'b1;
        mode_d   = op_mode_e'(op_mode);
        in_sec_d = 1'b0;
        rb_ph_d  = 1'b0;
        aerr_d   = 1'b0;
        eoc_d    = 1'b0;
        perr_d   = 1'b0;
        idxv_d   = 1'b0;
        wptr_d   = '0;
      end
      if (ld_count) cnt_d = cnt_in;
    end else if (op_stop) begin
      finish = 1'b1;
    end else if (mode_q == MODE_ADDR) begin
      if (addr_read) begin
        rbv_d = 1'b1;
        if (!rb_ph_q) begin
          rb_d    = DATA_W'(pos_cyl);
          rb_ph_d = 1'b1;
        end else begin
          rb_d                     = '0;
          rb_d[HEAD_LSB +: HEAD_W] = pos_head;
          rb_d[SEC_W-1:0]          = rar_sec;
          adv_o                    = 1'b1;
          finish                   = 1'b1;
        end
      end
    end else if (!in_sec_q) begin
      if (sector_start) begin
        if (mode_q == MODE_WRITE && wprot) begin
          perr_d = 1'b1;
          finish = 1'b1;
        end else if (addr_bad) begin
          aerr_d = 1'b1;
          finish = 1'b1;
        end else if (head_bad) begin
          eoc_d  = 1'b1;
          finish = 1'b1;
        end else begin
          in_sec_d = 1'b1;
          wptr_d   = '0;
          idx_d    = idx_calc;
          idxv_d   = 1'b1;
        end
      end
    end else if (word_done) begin
      wptr_d = wptr_q + 1'b1;
      if (mode_q == MODE_WRITE) fill_d = host_valid ? host_word : '0;
      if (wptr_q == WPTR_W'(WORDS - 1)) begin
        wptr_d   = '0;
        in_sec_d = 1'b0;
        adv_o    = 1'b1;
        carry_o  = 1'b1;
        if (mode_q == MODE_CHECK) begin
          cnt_d = cnt_q - 1'b1;
          if (cnt_q == CNT_W'(1)) finish = 1'b1;
        end
      end
    end
    if (finish) begin
      busy_d   = 1'b0;
      in_sec_d = 1'b0;
      done_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_READ;
      busy_q   <= 1'b0;
      in_sec_q <= 1'b0;
      rb_ph_q  <= 1'b0;
      aerr_q   <= 1'b0;
      eoc_q    <= 1'b0;
      perr_q   <= 1'b0;
      done_q   <= 1'b0;
      idxv_q   <= 1'b0;
      rbv_q    <= 1'b0;
      wptr_q   <= '0;
      cnt_q    <= '0;
      idx_q    <= '0;
      fill_q   <= '0;
      rb_q     <= '0;
    end else begin
      mode_q   <= mode_d;
      busy_q   <= busy_d;
      in_sec_q <= in_sec_d;
      rb_ph_q  <= rb_ph_d;
      aerr_q   <= aerr_d;
      eoc_q    <= eoc_d;
      perr_q   <= perr_d;
      done_q   <= done_d;
      idxv_q   <= idxv_d;
      rbv_q    <= rbv_d;
      wptr_q   <= wptr_d;
      cnt_q    <= cnt_d;
      idx_q    <= idx_d;
      fill_q   <= fill_d;
      rb_q     <= rb_d;
    end
  end

  assign busy_o        = busy_q;
  assign addr_err_o    = aerr_q;
  assign eoc_err_o     = eoc_q;
  assign prot_err_o    = perr_q;
  assign done_o        = done_q;
  assign index_o       = idx_q;
  assign index_valid_o = idxv_q;
  assign fill_o        = fill_q;
  assign rb_word_o     = rb_q;
  assign rb_valid_o    = rbv_q;

  // R11: the end pulse never lasts two cycles
  a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  // R3: a new address error coincides with the end of the operation
  a_r3_aerr_ends_op: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aerr_q) |-> (done_q && !busy_q));
  // R5: error flags are mutually exclusive
  a_r5_one_error: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({aerr_q, eoc_q, perr_q}));
  // R6: a valid index lies inside the addressable space
  a_r6_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    idxv_q |-> (idx_q < IDX_W'(IDX_MAX)));
endmodule

// File: rtl/disk_addr_seq.sv
module disk_addr_seq
  import das_pkg::*;
#(
  parameter int NUM_DRV  = 2,
  parameter int CYL_W    = 8,
  parameter int HEAD_W   = 5,
  parameter int SEC_W    = 5,
  parameter int SECS     = 23,
  parameter int HEADS    = 20,
  parameter int WORDS    = 128,
  parameter int CNT_W    = 9,
  parameter int DATA_W   = 16,
  parameter int HEAD_LSB = 8,
  localparam int IDX_W   = CYL_W + $clog2(HEADS) + $clog2(SECS),
  localparam int DRV_W   = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din,
  input  logic              ld_cyl,
  input  logic              ld_hs,
  input  logic              pos_load,
  input  logic              recal,
  input  logic [DRV_W-1:0]  drv_sel,
  input  logic [NUM_DRV-1:0] wr_prot,
  input  logic              ld_count,
  input  logic              op_start,
  input  logic [1:0]        op_mode,
  input  logic              op_stop,
  input  logic              sector_start,
  input  logic              word_done,
  input  logic              addr_read,
  input  logic              host_valid,
  input  logic [DATA_W-1:0] host_word,
  output logic              busy,
  output logic              op_done,
  output logic              addr_err,
  output logic              eoc_err,
  output logic              prot_err,
  output logic [IDX_W-1:0]  sector_index,
  output logic              index_valid,
  output logic [DATA_W-1:0] fill_word,
  output logic [DATA_W-1:0] rb_word,
  output logic              rb_valid,
  output logic [CYL_W-1:0]  rar_cyl,
  output logic [HEAD_W-1:0] rar_head,
  output logic [SEC_W-1:0]  rar_sec,
  output logic [CYL_W-1:0]  pos_cyl,
  output logic [HEAD_W-1:0] pos_head
);
  logic [1:0] rst_sync;
  logic       rst_i;
  logic       idle, adv, carry, wrap;
  logic       unused_din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i      = rst_sync[1];
  assign idle       = !busy;
  assign unused_din = ^din[DATA_W-1:HEAD_LSB+HEAD_W];

  das_rar #(.CYL_W(CYL_W), .HEAD_W(HEAD_W), .SEC_W(SEC_W), .SECS(SECS)) u_rar (
    .clk(clk), .rst_n(rst_i),
    .clr_i(recal && idle), .ld_cyl_i(ld_cyl && idle), .ld_hs_i(ld_hs && idle),
    .cyl_in(din[CYL_W-1:0]), .head_in(din[HEAD_LSB +: HEAD_W]), .sec_in(din[SEC_W-1:0]),
    .adv_i(adv), .carry_i(carry),
    .cyl_o(rar_cyl), .head_o(rar_head), .sec_o(rar_sec), .wrap_o(wrap));

  das_drive_bank #(.NUM_DRV(NUM_DRV), .CYL_W(CYL_W), .HEAD_W(HEAD_W)) u_drv (
    .clk(clk), .rst_n(rst_i), .sel_i(drv_sel),
    .load_i(pos_load && idle), .clr_i(recal && idle), .head_inc_i(wrap),
    .rar_cyl(rar_cyl), .rar_head(rar_head),
    .sel_cyl_o(pos_cyl), .sel_head_o(pos_head));

  das_ctrl #(.CYL_W(CYL_W), .HEAD_W(HEAD_W), .SEC_W(SEC_W), .SECS(SECS), .HEADS(HEADS),
             .WORDS(WORDS), .CNT_W(CNT_W), .DATA_W(DATA_W), .HEAD_LSB(HEAD_LSB),
             .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_i), .op_start(op_start), .op_mode(op_mode), .op_stop(op_stop),
    .sector_start(sector_start), .word_done(word_done), .addr_read(addr_read),
    .ld_count(ld_count), .cnt_in(din[CNT_W-1:0]), .host_valid(host_valid),
    .host_word(host_word), .wprot(wr_prot[drv_sel]),
    .rar_cyl(rar_cyl), .rar_head(rar_head), .rar_sec(rar_sec),
    .pos_cyl(pos_cyl), .pos_head(pos_head),
    .busy_o(busy), .addr_err_o(addr_err), .eoc_err_o(eoc_err), .prot_err_o(prot_err),
    .done_o(op_done), .index_o(sector_index), .index_valid_o(index_valid),
    .fill_o(fill_word), .rb_word_o(rb_word), .rb_valid_o(rb_valid),
    .adv_o(adv), .carry_o(carry));

  // R7: after a wrap the register head and the drive head still agree
  a_r7_head_agree: assert property (@(posedge clk) disable iff (!rst_i)
    wrap |=> ((drv_sel != $past(drv_sel)) || (rar_head == pos_head)));
  // R2: host loads never disturb the register during an operation
  a_r2_hold_when_busy: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && !adv && !$rose(busy)) |-> $stable(rar_cyl));
endmodule

// File: tb/sim_disk_addr_seq.sv
`timescale 1ns/1ps
module sim_disk_addr_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] din, host_word;
  logic        ld_cyl, ld_hs, pos_load, recal, drv_sel, ld_count, op_start, op_stop;
  logic [1:0]  wr_prot, op_mode;
  logic        sector_start, word_done, addr_read, host_valid;
  logic        busy, op_done, addr_err, eoc_err, prot_err, index_valid, rb_valid;
  logic [17:0] sector_index;
  logic [15:0] fill_word, rb_word;
  logic [7:0]  rar_cyl, pos_cyl;
  logic [4:0]  rar_head, rar_sec, pos_head;
  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  disk_addr_seq u0 (.*);

  localparam int NV = 6;
  localparam int TV [NV][4] = '{'{0, 0, 0, 0}, '{1, 0, 0, 1}, '{0, 202, 19, 22},
                                '{1, 7, 3, 11}, '{0, 255, 0, 5}, '{1, 100, 10, 0}};

  function automatic int lin(int c, int h, int s);
    return (c * 20 + h) * 23 + s;
  endfunction

  task automatic step(); @(negedge clk); endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load_cyl(input int c);
    din = 16'(c); ld_cyl = 1'b1; step(); ld_cyl = 1'b0;
  endtask
  task automatic load_hs(input int h, input int s);
    din = 16'((h << 8) | s); ld_hs = 1'b1; step(); ld_hs = 1'b0;
  endtask
  task automatic setpos(input int d, input int c, input int h, input int s);
    load_cyl(c); load_hs(h, s);
    drv_sel = d[0]; pos_load = 1'b1; step(); pos_load = 1'b0;
  endtask
  task automatic start(input int m);
    op_mode = 2'(m); op_start = 1'b1; step(); op_start = 1'b0;
  endtask
  task automatic sstart(); sector_start = 1'b1; step(); sector_start = 1'b0; endtask
  task automatic words(input int n);
    word_done = 1'b1; repeat (n) step(); word_done = 1'b0;
  endtask
  task automatic stop(); op_stop = 1'b1; step(); op_stop = 1'b0; endtask
  task automatic rd_addr(); addr_read = 1'b1; step(); addr_read = 1'b0; endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; din = '0; host_word = '0; ld_cyl = 0; ld_hs = 0; pos_load = 0;
    recal = 0; drv_sel = 0; wr_prot = '0; ld_count = 0; op_start = 0; op_mode = '0;
    op_stop = 0; sector_start = 0; word_done = 0; addr_read = 0; host_valid = 0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 rar", {rar_cyl, rar_head, rar_sec}, 0);
    chk("R1 pos", {pos_cyl, pos_head}, 0);
    chk("R1 errors", {addr_err, eoc_err, prot_err, index_valid, op_done}, 0);

    // R6/R2 table of positions and expected indices
    for (int i = 0; i < NV; i++) begin
      setpos(TV[i][0], TV[i][1], TV[i][2], TV[i][3]);
      chk("R2 field load", {rar_cyl, rar_head, rar_sec},
          {8'(TV[i][1]), 5'(TV[i][2]), 5'(TV[i][3])});
      start(0);
      sstart();
      chk("R6 index", sector_index, lin(TV[i][1], TV[i][2], TV[i][3]));
      chk("R6 valid", index_valid, 1);
      stop();
      chk("R11 stop pulse", {op_done, busy}, 2'b10);
    end

    // R7 wrap moves head in register and drive
    setpos(0, 5, 3, 22);
    start(0); sstart();
    words(127);
    chk("R7 no early advance", rar_sec, 22);
    words(1);
    chk("R7 sector wrap", rar_sec, 0);
    chk("R7 register head", rar_head, 4);
    chk("R7 drive head", pos_head, 4);
    sstart();
    chk("R7 next sector index", sector_index, lin(5, 4, 0));
    stop();

    // R3 miscompares in read and write
    setpos(0, 5, 3, 4); load_cyl(6);
    start(0); sstart();
    chk("R3 read cyl miscompare", {addr_err, busy, op_done}, 3'b101);
    setpos(1, 9, 2, 1); load_hs(3, 1);
    start(1); sstart();
    chk("R3 write head miscompare", {addr_err, busy}, 2'b10);
    setpos(1, 9, 2, 23);
    start(0); sstart();
    chk("R3 sector 23", addr_err, 1);

    // R4 head past last track
    setpos(0, 10, 20, 0);
    start(0); sstart();
    chk("R4 eoc", {eoc_err, addr_err, busy}, 3'b100);

    // R5 protection wins over miscompare
    wr_prot = 2'b10;
    setpos(1, 10, 2, 0); load_cyl(11);
    start(1); sstart();
    chk("R5 protect", {prot_err, addr_err, busy}, 3'b100);

    // R10 fill words on unprotected drive 0
    setpos(0, 10, 2, 0);
    start(1); sstart();
    chk("R5 unprotected accepted", {busy, prot_err}, 2'b10);
    host_valid = 1'b1; host_word = 16'hBEEF;
    words(1);
    chk("R10 host word", fill_word, 16'hBEEF);
    host_valid = 1'b0;
    words(1);
    chk("R10 zero fill", fill_word, 0);
    stop();
    wr_prot = 2'b00;

    // R8 check budget of two sectors
    din = 16'd2; ld_count = 1'b1; step(); ld_count = 1'b0;
    setpos(0, 1, 1, 0);
    start(2); sstart(); words(128);
    chk("R8 budget left", {busy, rar_sec}, {1'b1, 5'd1});
    sstart(); words(128);
    chk("R8 budget spent", {busy, op_done, rar_sec}, {1'b0, 1'b1, 5'd2});

    // R9 address readback
    setpos(1, 9, 2, 22);
    start(3); rd_addr();
    chk("R9 first word", {rb_valid, busy, rb_word}, {2'b11, 16'd9});
    rd_addr();
    chk("R9 second word", rb_word, 16'h0216);
    chk("R9 ends and advances", {busy, rar_sec, rar_head}, {1'b0, 5'd0, 5'd2});

    // R2 loads ignored while busy, recalibrate
    setpos(0, 4, 4, 4);
    start(0);
    load_cyl(77); load_hs(9, 9);
    chk("R2 ignored when busy", {rar_cyl, rar_head, rar_sec}, {8'd4, 5'd4, 5'd4});
    stop();
    drv_sel = 1'b0; recal = 1'b1; step(); recal = 1'b0;
    chk("R2 recal", {rar_cyl, rar_sec, pos_cyl, pos_head}, 0);
    drv_sel = 1'b1; step();
    chk("R2 other drive kept", pos_cyl, 9);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule